// File: doc/BRIEF.md
# Pin Bank with Edge and Level Interrupts

This block is a bank of general-purpose pins controlled through a small word-addressed register bus. Software sets the value each pin should drive and chooses, pin by pin, whether that value reaches the pad. It can read back the synchronized pin levels at any time. Any pin can also be connected to a detector that watches for a rising edge, a falling edge, a high level or a low level.

Detected events set sticky status bits. An enable mask selects which status bits contribute to one shared interrupt line for the bank. Every writable register has three write views at neighbouring word addresses:

- plain replace,
- OR-in of the written mask,
- clear of the bits set in the written mask.

These views let a driver change single bits without a read-modify-write. Status can only be cleared, and only through its clear view. A level-type pin keeps setting its status bit for as long as the level persists.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads zero, `pad_oe` is all zero and `irq` is low.
- R2: A bus address splits into a register index in bits [5:2] and a write view in bits [1:0]. View 0 replaces the register, view 1 ORs the data into it, view 2 clears the bits that are one in the data, and view 3 writes nothing. The indices are: 0 drive value, 1 drive enable, 2 input levels, 3 interrupt routing, 4 interrupt enable, 5 trigger kind, 6 trigger sense, 7 status.
- R3: `pad_oe` equals the drive-enable register. `pad_o` carries the drive-value bit where enabled and is zero elsewhere.
- R4: Register 2 returns the pad levels after a two-flop synchronizer, whatever the drive enables are. Writes to register 2 have no effect.
- R5: A trigger-kind bit of 0 selects edge detection and 1 selects level detection. A trigger-sense bit of 0 selects falling/low and 1 selects rising/high. Edges compare the synchronized value with its value one clock earlier.
- R6: A pin whose routing bit is 0 never sets its status bit.
- R7: A status bit, once set, stays set until a view-2 write to register 7 has that bit at one. View-0 and view-1 writes to register 7 change nothing.
- R8: A detected event sets its status bit on the next clock. If an event and a clear hit the same bit in the same cycle, the event wins. An active level therefore keeps its status bit set through a clear.
- R9: `irq` is high exactly when some status bit and its enable bit are both one.
- R10: A read (`bus_re`) returns the indexed register on `bus_rdata` after the next rising clock edge. The write view is ignored for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 6 | Word address: register index and write view |
| bus_wdata | input | 32 | Write data / bit mask |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Raw pin levels |
| pad_o | output | 32 | Value driven to each pin |
| pad_oe | output | 32 | Per-pin drive enable |
| irq | output | 1 | Combined bank interrupt |

## Verification
The detector is tried in all four trigger modes, each with one pin transition that should fire it and one that should not. This separates the trigger-kind bit from the trigger-sense bit, and edge detection from a stale level. Level modes are also held active across a status clear to show that the event beats the clear, then released to show that the clear takes effect. Routing, enable masking, the write views on several registers, and readback of the input levels with drives disabled are tried as separate directed patterns. Together they separate a missing mask from a wrong write view.

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int NPINS = 32,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic             bus_re,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_o,
  output logic [NPINS-1:0] pad_oe,
  output logic             irq
);
  localparam int IW = AW - 2;
  localparam logic [IW-1:0] R_DOUT  = IW'(0);
  localparam logic [IW-1:0] R_OE    = IW'(1);
  localparam logic [IW-1:0] R_DIN   = IW'(2);
  localparam logic [IW-1:0] R_ROUTE = IW'(3);
  localparam logic [IW-1:0] R_IEN   = IW'(4);
  localparam logic [IW-1:0] R_KIND  = IW'(5);
  localparam logic [IW-1:0] R_SENSE = IW'(6);
  localparam logic [IW-1:0] R_STAT  = IW'(7);
  localparam logic [1:0] V_PUT = 2'd0;
  localparam logic [1:0] V_OR  = 2'd1;
  localparam logic [1:0] V_CLR = 2'd2;

  logic [NPINS-1:0] dout_q, oe_q, route_q, ien_q, kind_q, sense_q, stat_q;
  logic [NPINS-1:0] sy1, sy2, sy_prev;
  logic [NPINS-1:0] evt, stat_clr;

  wire [IW-1:0] idx  = bus_addr[AW-1:2];
  wire [1:0]    view = bus_addr[1:0];

  function automatic logic [NPINS-1:0] apply(input logic [NPINS-1:0] cur,
                                             input logic [1:0] v,
                                             input logic [NPINS-1:0] w);
    case (v)
      V_PUT:   return w;
      V_OR:    return cur | w;
      V_CLR:   return cur & ~w;
      default: return cur;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0; oe_q <= '0; route_q <= '0;
      ien_q  <= '0; kind_q <= '0; sense_q <= '0;
    end else if (bus_we) begin
      case (idx)
        R_DOUT:  dout_q  <= apply(dout_q,  view, bus_wdata);
        R_OE:    oe_q    <= apply(oe_q,    view, bus_wdata);
        R_ROUTE: route_q <= apply(route_q, view, bus_wdata);
        R_IEN:   ien_q   <= apply(ien_q,   view, bus_wdata);
        R_KIND:  kind_q  <= apply(kind_q,  view, bus_wdata);
        R_SENSE: sense_q <= apply(sense_q, view, bus_wdata);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= '0; sy2 <= '0; sy_prev <= '0;
    end else begin
      sy1 <= pad_in; sy2 <= sy1; sy_prev <= sy2;
    end
  end

  wire [NPINS-1:0] rise     = sy2 & ~sy_prev;
  wire [NPINS-1:0] fall     = ~sy2 & sy_prev;
  wire [NPINS-1:0] lvl_hit  = ~(sy2 ^ sense_q);
  wire [NPINS-1:0] edge_hit = (rise & sense_q) | (fall & ~sense_q);
  assign evt = route_q & ((kind_q & lvl_hit) | (~kind_q & edge_hit));

  assign stat_clr = (bus_we && idx == R_STAT && view == V_CLR) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~stat_clr) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_re) begin
      case (idx)
        R_DOUT:  bus_rdata <= dout_q;
        R_OE:    bus_rdata <= oe_q;
        R_DIN:   bus_rdata <= sy2;
        R_ROUTE: bus_rdata <= route_q;
        R_IEN:   bus_rdata <= ien_q;
        R_KIND:  bus_rdata <= kind_q;
        R_SENSE: bus_rdata <= sense_q;
        R_STAT:  bus_rdata <= stat_q;
        default: bus_rdata <= '0;
      endcase
    end
  end

  assign pad_oe = oe_q;
  assign pad_o  = dout_q & oe_q;
  assign irq    = |(stat_q & ien_q);

  assert_oe_put_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && idx == R_OE && view == V_PUT) |=> (pad_oe == $past(bus_wdata)));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && idx == R_STAT && view == V_CLR) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  assert_unrouted_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(route_q)) == '0));

  assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(evt)) == $past(evt)));

  assert_irq_off_when_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);
endmodule

// File: tb/sim_gpio_irq_bank.sv
module sim_gpio_irq_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, pad_in = '0, pad_o, pad_oe;
  logic irq;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  gpio_irq_bank u0 (.clk, .rst_n, .bus_we, .bus_re, .bus_addr, .bus_wdata,
                    .bus_rdata, .pad_in, .pad_o, .pad_oe, .irq);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input int r, input int v, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = {r[3:0], v[1:0]}; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input int r, output logic [31:0] d);
    @(negedge clk); bus_re = 1'b1; bus_addr = {r[3:0], 2'd0};
    @(posedge clk); #1 d = bus_rdata;
    @(negedge clk); bus_re = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {kind, sense, pad_before, pad_after, expected status bit 0}
  localparam logic [4:0] VEC [8] = '{
    5'b00_10_1, 5'b00_01_0, 5'b01_01_1, 5'b01_10_0,
    5'b10_00_1, 5'b10_11_0, 5'b11_11_1, 5'b11_00_0 };

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    settle(2); rst_n = 1'b1; settle(2);

    // R1 reset state
    for (int r = 0; r < 8; r++) begin rd(r, d); chk("R1 reg reset", d, 32'h0); end
    chk("R1 pad_oe", pad_oe, 0); chk("R1 irq", {31'b0, irq}, 0);

    // R2 write views on several registers, R10 read timing
    wr(0, 0, 32'h0000_00F0); wr(0, 1, 32'h0000_0003); wr(0, 2, 32'h0000_0010);
    rd(0, d); chk("R2 drive value views", d, 32'h0000_00E3);
    wr(0, 3, 32'hFFFF_FFFF); rd(0, d); chk("R2 view 3 no write", d, 32'h0000_00E3);
    wr(4, 1, 32'h8000_0001); wr(4, 2, 32'h0000_0001); rd(4, d);
    chk("R2 enable views", d, 32'h8000_0000);
    wr(4, 0, 0);

    // R3 pad gating
    wr(1, 0, 32'h0000_00A1); settle(1);
    chk("R3 pad_oe", pad_oe, 32'h0000_00A1);
    chk("R3 pad_o", pad_o, 32'h0000_00A1 & 32'h0000_00E3);
    wr(1, 0, 0); settle(1); chk("R3 pad_o off", pad_o, 0);

    // R4 input readback independent of drive enables, write ignored
    pad_in = 32'h5A5A_0000; settle(3);
    rd(2, d); chk("R4 din readback", d, 32'h5A5A_0000);
    wr(2, 0, 32'hFFFF_FFFF); rd(2, d); chk("R4 din write ignored", d, 32'h5A5A_0000);
    pad_in = 0; settle(4);

    // R5 trigger modes via vector table on pin 0
    wr(3, 0, 32'h1);
    for (int i = 0; i < 8; i++) begin
      wr(5, 0, {31'b0, VEC[i][4]}); wr(6, 0, {31'b0, VEC[i][3]});
      pad_in[0] = VEC[i][2]; settle(5);
      wr(7, 2, 32'hFFFF_FFFF);
      pad_in[0] = VEC[i][1]; settle(5);
      rd(7, d); chk($sformatf("R5 mode vector %0d", i), {31'b0, d[0]}, {31'b0, VEC[i][0]});
    end
    wr(7, 2, 32'hFFFF_FFFF);

    // R8 level held through a clear, then released
    wr(5, 0, 32'h1); wr(6, 0, 32'h1); pad_in[0] = 1'b1; settle(4);
    wr(7, 2, 32'h1); rd(7, d); chk("R8 event beats clear", d, 32'h1);
    pad_in[0] = 1'b0; settle(4); wr(7, 2, 32'h1); rd(7, d);
    chk("R8 clear after release", d, 32'h0);

    // R6 unrouted pin ignored
    wr(3, 0, 32'h1); wr(5, 0, 0); wr(6, 0, 32'h0000_0004);
    pad_in[2] = 1'b1; settle(5); rd(7, d); chk("R6 unrouted no status", d, 32'h0);
    pad_in[2] = 1'b0; settle(4);

    // R7 sticky, only clear view clears
    wr(3, 0, 32'h8); wr(6, 0, 32'h8);
    pad_in[3] = 1'b1; settle(5); pad_in[3] = 1'b0; settle(5);
    rd(7, d); chk("R7 edge captured", d, 32'h8);
    wr(7, 0, 32'h0); wr(7, 1, 32'h0000_0100); rd(7, d);
    chk("R7 put/or views ignored", d, 32'h8);

    // R9 interrupt masking
    chk("R9 masked irq low", {31'b0, irq}, 0);
    wr(4, 1, 32'h8); settle(1); chk("R9 irq high", {31'b0, irq}, 1);
    wr(7, 2, 32'h8); settle(1); chk("R9 irq after clear", {31'b0, irq}, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule